// File: doc/BRIEF.md
# DCC Track Waveform Generator

This block drives one model-railway track signal pin with an unbroken stream of DCC packets. Each bit is a high interval followed by a low interval of the same length. A short interval stands for a 1 and a long interval stands for a 0. Every packet opens with a run of 1 bits and a single 0 start bit. The data bytes follow, each separated from the next by a 0. A final 1 closes the packet. The next packet's preamble starts on the very next clock, so the pin never rests.

A host hands over a packet through a valid/ready load port. It supplies the packed bytes, a byte count and a repeat count, and it computes any checksum byte itself. The block takes a packet only when nothing is queued and the previous packet has finished its repeats. When no packet is waiting, the block sends a fixed idle packet. A one-cycle strobe marks the first clock of every packet. Half-period lengths are given in clock cycles through parameters. An optional debug setting lengthens the start bit so that an oscilloscope can trigger on it.

Top module: `dcc_wavegen`

## Requirements
- R1: Every bit is a high half followed by a low half of equal length. The half lasts HALF1_CYC cycles for a 1 bit and HALF0_CYC cycles for a 0 bit.
- R2: Every packet begins with PREAMBLE_BITS 1 bits, followed by one 0 start bit.
- R3: Data bytes go out in order from byte 0 (`load_data_i[7:0]`) upward, each most-significant bit first. A 0 separator bit follows every byte except the last.
- R4: A 1 end bit follows the last byte. The next preamble starts on the following clock. `pkt_start_o` is high exactly in the first cycle of each packet, and it is high only while `dcc_o` is high.
- R5: In the cycles after reset, `dcc_o` is 1, `pkt_start_o` is 1 and `load_ready_o` is 1. The first packet is the idle packet.
- R6: `load_ready_o` is 1 only when no loaded packet is waiting and the repeat count is zero. A load is taken when `load_valid_i` and `load_ready_o` are both high at a clock edge and 1 <= `load_count_i` <= MAX_BYTES. A valid load while `load_ready_o` is low has no effect.
- R7: A load whose count is 0 or above MAX_BYTES is ignored. `load_ready_o` stays high and the output carries on as if no load had been offered.
- R8: A packet taken with repeat count N goes out in N+1 consecutive packets. The count drops by one at each packet boundary after the first send, and `load_ready_o` rises in the first cycle of the last copy.
- R9: A packet taken during one packet goes out as the next packet. `load_ready_o` returns high in its first cycle when N is 0.
- R10: When nothing is pending, the idle packet is sent: bytes 0xFF, 0x00, 0xFF. With DEBUG_MARK set, both halves of the start bit last HALF0_CYC + HALF0_CYC/10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_valid_i | input | 1 | Host offers a packet |
| load_ready_o | output | 1 | Block can take a packet |
| load_data_i | input | MAX_BYTES*8 | Packet bytes, byte 0 in bits 7:0 |
| load_count_i | input | $clog2(MAX_BYTES+1) | Number of bytes in the packet |
| load_repeat_i | input | REP_W | Extra copies to send after the first |
| dcc_o | output | 1 | Track signal |
| pkt_start_o | output | 1 | High in the first cycle of each packet |

## Verification
The bound checker watches four things on every cycle. It checks that each level run lasts between the short and the stretched long half-period. It checks that the packet strobe falls only in a high interval that follows a low one. It checks that the ready flag rises only at a packet start. It checks how ready responds to a valid, an invalid and an out-of-range load. The order of bits, the byte and separator layout, the substitution of the idle packet and the exact number of repeated copies depend on which packet was taken and when. Only the bench's cycle-by-cycle model shows these, across scenarios that include back-to-back loads during a final repeat and rejected counts.

// File: rtl/dcc_wave_pkg.sv
package dcc_wave_pkg;
  typedef enum logic [1:0] {FS_PRE, FS_START, FS_DATA} frame_state_e;
  localparam int          IDLE_LEN   = 3;
  localparam logic [23:0] IDLE_BYTES = 24'hFF00FF;
endpackage

// File: rtl/dcc_bit_timer.sv
module dcc_bit_timer #(
  parameter int HALF1_CYC   = 29,
  parameter int HALF0_CYC   = 50,
  parameter int STRETCH_CYC = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_val_i,
  input  logic long_i,
  output logic level_o,
  output logic bit_first_o,
  output logic bit_done_o
);
  localparam int CNT_W = $clog2(HALF0_CYC + STRETCH_CYC + 1);

  logic             hi_q;
  logic [CNT_W-1:0] cnt_q, half_m1;
  logic             at_end;

  always_comb begin
    if (bit_val_i)   half_m1 = CNT_W'(HALF1_CYC - 1);
    else if (long_i) half_m1 = CNT_W'(HALF0_CYC + STRETCH_CYC - 1);
    else             half_m1 = CNT_W'(HALF0_CYC - 1);
  end

  assign at_end = (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b1;
      cnt_q <= '0;
    end else if (at_end) begin
      hi_q  <= ~hi_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o     = hi_q;
  assign bit_first_o = hi_q && (cnt_q == '0);
  assign bit_done_o  = !hi_q && at_end;
endmodule

// File: rtl/dcc_frame_seq.sv
module dcc_frame_seq
  import dcc_wave_pkg::*;
#(
  parameter int PREAMBLE_BITS = 14,
  parameter int MAX_BYTES     = 6,
  parameter int LEN_W         = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bit_done_i,
  input  logic [MAX_BYTES*8-1:0] pkt_data_i,
  input  logic [LEN_W-1:0]       pkt_len_i,
  output logic                   bit_val_o,
  output logic                   long_o,
  output logic                   frame_head_o,
  output logic                   frame_end_o
);
  localparam int PRE_W = (PREAMBLE_BITS > 1) ? $clog2(PREAMBLE_BITS) : 1;
  localparam int BYI_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  frame_state_e     state_q;
  logic [PRE_W-1:0] pre_q;
  logic [BYI_W-1:0] byte_q;
  logic [3:0]       bit_q;   // 0..7 data, 8 separator/end
  logic [7:0]       bytes [MAX_BYTES];
  logic [7:0]       cur_byte;
  logic             last_byte, sep_slot;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bytes
    assign bytes[g] = pkt_data_i[g*8 +: 8];
  end

  assign cur_byte  = bytes[byte_q];
  assign last_byte = (LEN_W'(byte_q) + LEN_W'(1)) == pkt_len_i;
  assign sep_slot  = (bit_q == 4'd8);

  always_comb begin
    long_o = 1'b0;
    unique case (state_q)
      FS_PRE:   bit_val_o = 1'b1;
      FS_START: begin
        bit_val_o = 1'b0;
        long_o    = 1'b1;
      end
      default:  bit_val_o = sep_slot ? last_byte : cur_byte[3'd7 - bit_q[2:0]];
    endcase
  end

  assign frame_head_o = (state_q == FS_PRE) && (pre_q == '0);
  assign frame_end_o  = bit_done_i && (state_q == FS_DATA) && sep_slot && last_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_PRE;
      pre_q   <= '0;
      byte_q  <= '0;
      bit_q   <= '0;
    end else if (bit_done_i) begin
      unique case (state_q)
        FS_PRE: begin
          if (pre_q == PRE_W'(PREAMBLE_BITS - 1)) begin
            pre_q   <= '0;
            state_q <= FS_START;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        FS_START: begin
          state_q <= FS_DATA;
          byte_q  <= '0;
          bit_q   <= '0;
        end
        default: begin
          if (!sep_slot) begin
            bit_q <= bit_q + 4'd1;
          end else if (last_byte) begin
            state_q <= FS_PRE;
          end else begin
            byte_q <= byte_q + 1'b1;
            bit_q  <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dcc_pkt_store.sv
module dcc_pkt_store
  import dcc_wave_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int REP_W     = 4,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_valid_i,
  output logic                   load_ready_o,
  input  logic [MAX_BYTES*8-1:0] load_data_i,
  input  logic [LEN_W-1:0]       load_count_i,
  input  logic [REP_W-1:0]       load_repeat_i,
  input  logic                   frame_end_i,
  output logic [MAX_BYTES*8-1:0] act_data_o,
  output logic [LEN_W-1:0]       act_len_o
);
  localparam logic [MAX_BYTES*8-1:0] IDLE_DATA = (MAX_BYTES*8)'(IDLE_BYTES);
  localparam logic [LEN_W-1:0]       IDLE_CNT  = LEN_W'(IDLE_LEN);

  logic [MAX_BYTES*8-1:0] stg_data_q, act_data_q;
  logic [LEN_W-1:0]       stg_len_q, act_len_q;
  logic [REP_W-1:0]       rep_q;
  logic                   pend_q, len_ok, take;

  assign load_ready_o = !pend_q && (rep_q == '0);
  assign len_ok       = (load_count_i != '0) && (load_count_i <= LEN_W'(MAX_BYTES));
  assign take         = load_valid_i && load_ready_o && len_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_data_q <= '0;
      stg_len_q  <= '0;
      act_data_q <= IDLE_DATA;
      act_len_q  <= IDLE_CNT;
      rep_q      <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (frame_end_i) begin
        if (pend_q) begin
          act_data_q <= stg_data_q;
          act_len_q  <= stg_len_q;
          pend_q     <= 1'b0;
        end else if (rep_q != '0) begin
          rep_q <= rep_q - 1'b1;
        end else begin
          act_data_q <= IDLE_DATA;
          act_len_q  <= IDLE_CNT;
        end
      end
      // take implies pend_q==0 and rep_q==0, so no conflict with the above
      if (take) begin
        stg_data_q <= load_data_i;
        stg_len_q  <= load_count_i;
        rep_q      <= load_repeat_i;
        pend_q     <= 1'b1;
      end
    end
  end

  assign act_data_o = act_data_q;
  assign act_len_o  = act_len_q;
endmodule

// File: rtl/dcc_wavegen.sv
module dcc_wavegen #(
  parameter int   PREAMBLE_BITS = 14,
  parameter int   HALF1_CYC     = 29,
  parameter int   HALF0_CYC     = 50,
  parameter int   MAX_BYTES     = 6,
  parameter int   REP_W         = 4,
  parameter bit   DEBUG_MARK    = 1'b0,
  localparam int  LEN_W         = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_valid_i,
  output logic                   load_ready_o,
  input  logic [MAX_BYTES*8-1:0] load_data_i,
  input  logic [LEN_W-1:0]       load_count_i,
  input  logic [REP_W-1:0]       load_repeat_i,
  output logic                   dcc_o,
  output logic                   pkt_start_o
);
  localparam int STRETCH_CYC = DEBUG_MARK ? HALF0_CYC / 10 : 0;

  logic                   bit_val, long_bit, bit_first, bit_done;
  logic                   frame_head, frame_end;
  logic [MAX_BYTES*8-1:0] act_data;
  logic [LEN_W-1:0]       act_len;

  dcc_pkt_store #(
    .MAX_BYTES(MAX_BYTES), .REP_W(REP_W), .LEN_W(LEN_W)
  ) store_i (
    .clk_i, .rst_ni,
    .load_valid_i, .load_ready_o, .load_data_i, .load_count_i, .load_repeat_i,
    .frame_end_i(frame_end),
    .act_data_o(act_data),
    .act_len_o(act_len)
  );

  dcc_frame_seq #(
    .PREAMBLE_BITS(PREAMBLE_BITS), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
  ) seq_i (
    .clk_i, .rst_ni,
    .bit_done_i(bit_done),
    .pkt_data_i(act_data),
    .pkt_len_i(act_len),
    .bit_val_o(bit_val),
    .long_o(long_bit),
    .frame_head_o(frame_head),
    .frame_end_o(frame_end)
  );

  dcc_bit_timer #(
    .HALF1_CYC(HALF1_CYC), .HALF0_CYC(HALF0_CYC), .STRETCH_CYC(STRETCH_CYC)
  ) timer_i (
    .clk_i, .rst_ni,
    .bit_val_i(bit_val),
    .long_i(long_bit),
    .level_o(dcc_o),
    .bit_first_o(bit_first),
    .bit_done_o(bit_done)
  );

  assign pkt_start_o = frame_head && bit_first;
endmodule

// File: rtl/dcc_wavegen_chk.sv
module dcc_wavegen_chk #(
  parameter int HALF1_CYC  = 29,
  parameter int HALF0_CYC  = 50,
  parameter int MAX_BYTES  = 6,
  parameter bit DEBUG_MARK = 1'b0,
  parameter int LEN_W      = $clog2(MAX_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_valid_i,
  input logic             load_ready_o,
  input logic [LEN_W-1:0] load_count_i,
  input logic             dcc_o,
  input logic             pkt_start_o
);
  localparam int MAX_HALF = HALF0_CYC + (DEBUG_MARK ? HALF0_CYC / 10 : 0);
  localparam int RUN_W    = $clog2(MAX_HALF + 2) + 1;

  logic             prev_q, seen_q;
  logic [RUN_W-1:0] run_q;
  logic             cnt_ok;

  assign cnt_ok = (load_count_i != '0) && (load_count_i <= LEN_W'(MAX_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= dcc_o;
      seen_q <= 1'b1;
      run_q  <= (dcc_o != prev_q) ? RUN_W'(1) : run_q + 1'b1;
    end
  end

  // R1: every level run lasts one legal half-period
  p_half_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcc_o != prev_q) |-> (run_q >= RUN_W'(HALF1_CYC)) && (run_q <= RUN_W'(MAX_HALF)));

  // R4: packet strobe only on the first high cycle after a low half
  p_start_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_start_o && seen_q) |-> (dcc_o && !prev_q));

  // R8: ready can only come back at a packet boundary
  p_ready_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_ready_o) |-> pkt_start_o);

  // R6: a taken load drops ready on the next cycle
  p_take_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_i && load_ready_o && cnt_ok) |=> !load_ready_o);

  // R7: a bad count leaves ready high
  p_bad_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_i && load_ready_o && !cnt_ok) |=> load_ready_o);
endmodule

bind dcc_wavegen dcc_wavegen_chk #(
  .HALF1_CYC(HALF1_CYC), .HALF0_CYC(HALF0_CYC),
  .MAX_BYTES(MAX_BYTES), .DEBUG_MARK(DEBUG_MARK), .LEN_W(LEN_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .load_valid_i(load_valid_i), .load_ready_o(load_ready_o),
  .load_count_i(load_count_i), .dcc_o(dcc_o), .pkt_start_o(pkt_start_o)
);

// File: tb/dcc_wavegen_tb_top.sv
module dcc_wavegen_tb_top;
  localparam int PRE = 10;
  localparam int H1  = 4;
  localparam int H0  = 20;
  localparam int ST  = H0 / 10;
  localparam int MB  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [47:0] load_data = '0;
  logic [2:0]  load_count = '0;
  logic [3:0]  load_repeat = '0;
  logic        dcc, pkt_start;

  always #2 clk = ~clk;

  dcc_wavegen #(
    .PREAMBLE_BITS(PRE), .HALF1_CYC(H1), .HALF0_CYC(H0),
    .MAX_BYTES(MB), .REP_W(4), .DEBUG_MARK(1'b1)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .load_valid_i(load_valid), .load_ready_o(load_ready),
    .load_data_i(load_data), .load_count_i(load_count), .load_repeat_i(load_repeat),
    .dcc_o(dcc), .pkt_start_o(pkt_start)
  );

  int checks = 0;
  int errors = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tname(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R10";
    endcase
  endfunction

  // ---- behavioural reference model ----
  int q[$];           // entry: level | start<<1 | tag<<4
  bit pend_m;
  int rep_m;
  int stg_m[MB], act_m[MB];
  int stg_len, act_len;
  int frames_m, frames_d;
  bit rdy_m, acc_m;

  task automatic push_bit(int v, bit lng, int tag, bit first);
    int h;
    h = v ? H1 : (H0 + (lng ? ST : 0));
    for (int i = 0; i < h; i++) q.push_back(1 | ((first && i == 0) ? 2 : 0) | (tag << 4));
    for (int i = 0; i < h; i++) q.push_back(0 | (tag << 4));
  endtask

  task automatic build();
    for (int p = 0; p < PRE; p++) push_bit(1, 1'b0, 2, p == 0);
    push_bit(0, 1'b1, 10, 1'b0);
    for (int b = 0; b < act_len; b++) begin
      for (int i = 7; i >= 0; i--) push_bit((act_m[b] >> i) & 1, 1'b0, 3, 1'b0);
      if (b == act_len - 1) push_bit(1, 1'b0, 4, 1'b0);
      else                  push_bit(0, 1'b0, 3, 1'b0);
    end
    frames_m++;
  endtask

  task automatic set_idle();
    act_m[0] = 8'hFF; act_m[1] = 8'h00; act_m[2] = 8'hFF; act_len = 3;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      pend_m = 1'b0; rep_m = 0; frames_m = 0;
      set_idle();
      build();
    end else begin
      rdy_m = !pend_m && rep_m == 0;
      acc_m = load_valid && rdy_m && load_count >= 1 && load_count <= MB;
      void'(q.pop_front());
      if (q.size() == 0) begin
        if (pend_m) begin
          act_m = stg_m; act_len = stg_len; pend_m = 1'b0;
        end else if (rep_m > 0) begin
          rep_m--;
        end else begin
          set_idle();
        end
        build();
      end
      if (acc_m) begin
        for (int b = 0; b < MB; b++) stg_m[b] = int'(load_data[b*8 +: 8]);
        stg_len = int'(load_count);
        rep_m   = int'(load_repeat);
        pend_m  = 1'b1;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (run_chk && !done) begin
      int e;
      e = q[0];
      chk(dcc === e[0], tname(e >> 4), int'(dcc), e & 1);      // R1 R2 R3 R4 R10
      chk(pkt_start === e[1], "R4", int'(pkt_start), (e >> 1) & 1);
      chk(load_ready === (!pend_m && rep_m == 0), "R6", int'(load_ready),
          int'(!pend_m && rep_m == 0));
      if (pkt_start) frames_d++;
    end
  end

  task automatic offer(logic [47:0] d, int n, int r, bit wait_rdy);
    @(negedge clk);
    if (wait_rdy) while (!load_ready) @(negedge clk);
    load_valid  = 1'b1;
    load_data   = d;
    load_count  = 3'(n);
    load_repeat = 4'(r);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic starts_to_ready(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (pkt_start) n++;
      if (load_ready) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    frames_d = 1;
    repeat (3) @(negedge clk);
    // R5: reset outputs
    chk(dcc === 1'b1, "R5", int'(dcc), 1);
    chk(pkt_start === 1'b1, "R5", int'(pkt_start), 1);
    chk(load_ready === 1'b1, "R5", int'(load_ready), 1);
    rst_n = 1'b1;
    @(posedge clk);
    run_chk = 1'b1;
    repeat (900) @(negedge clk);            // idle packets (R10)

    // R9: single packet, no repeat
    offer(48'h0000_0000_3CA5, 2, 0, 1'b1);
    starts_to_ready(n);
    chk(n == 1, "R9", n, 1);

    // R7: bad counts ignored
    offer(48'h0000_0000_0055, 7, 3, 1'b1);
    chk(load_ready === 1'b1, "R7", int'(load_ready), 1);
    offer(48'h0000_0000_0055, 0, 3, 1'b1);
    chk(load_ready === 1'b1, "R7", int'(load_ready), 1);
    repeat (700) @(negedge clk);

    // R8: six bytes, two repeats; R6: offers while busy ignored
    offer(48'h0102_8040_7EC3, 6, 2, 1'b1);
    n = 0;
    load_valid = 1'b1; load_data = 48'hFFFF_FFFF_FFFF; load_count = 3'd1; load_repeat = 4'd5;
    repeat (40) begin
      @(negedge clk);
      if (pkt_start) n++;
    end
    load_valid = 1'b0;
    forever begin
      if (load_ready) break;
      @(negedge clk);
      if (pkt_start) n++;
    end
    chk(n == 3, "R8", n, 3);

    // back-to-back during last repeat
    offer(48'h0000_0000_0001, 1, 1, 1'b0);
    starts_to_ready(n);
    chk(n == 2, "R8", n, 2);
    repeat (2000) @(negedge clk);
    chk(frames_d == frames_m, "R4", frames_d, frames_m);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule